// File: doc/BRIEF.md
# Shift-Pattern Fractional Clock Divider

This block derives a slower clock from a fast input clock. It circulates a bit pattern around a ring register and puts the head bit of the ring on the output, so one ring lap produces as many output periods as the pattern has runs of ones. Because the ring can be 12, 14, 15 or 25 bits long, patterns can produce half-step and quarter-step average ratios as well as whole-number ones. Examples are 2.5, 3.5, 3.75, 6.25 and 7.5. A bypass setting passes the input clock straight to the output.

Control comes from one 20-bit word with these fields:

- bit 19: output enable.
- bit 18: bypass.
- bits 17:16: ring-length select.
- bit 15: preset strobe.
- bits 14:0: preset pattern.

Software clears the enable before it reconfigures the divider. It raises the strobe with the select and pattern present, drops the strobe, and then sets the enable again.

A small state machine tracks the control word. It has four states:

- `ST_OFF`: output gated, ring frozen.
- `ST_ARM`: preset being loaded.
- `ST_RUN`: ring rotating.
- `ST_PASS`: bypass.

The machine has these transitions:

- `ST_OFF→ST_ARM` when the strobe rises while the enable is low.
- `ST_ARM→ST_OFF` when the strobe is cleared.
- Any state to `ST_RUN` when the enable is high and bypass is low.
- Any state to `ST_PASS` when the enable and bypass are both high.
- `ST_RUN` or `ST_PASS` to `ST_OFF` (or to `ST_ARM` if the strobe is high) when the enable is cleared.

Top module: `fdiv_shift_top`

## Requirements
- R1: A synchronous reset clears the ring to all zeros, selects ring length 12, places the machine in `ST_OFF` and drives `clk_out` low. Enabling the divider after reset without a preset keeps `clk_out` low.
- R2: With enable (bit 19) and bypass (bit 18) both high, from the next rising edge `clk_out` equals `clk`: high while `clk` is high and low while it is low.
- R3: With enable low, `clk_out` is low after the next rising edge and the ring keeps its position. Setting enable again resumes the sequence from the bit where it stopped.
- R4: While enable is low, a high strobe (bit 15) loads the pattern (bits 14:0) and the select (bits 17:16) into the ring. Clearing the strobe keeps the loaded contents.
- R5: The select chooses the ring length: 0 gives 12 bits, 1 gives 14 bits and 2 gives 15 bits. In `ST_RUN` the ring rotates one position per input cycle. `clk_out` is the registered head bit, which is the highest bit inside the ring length. The first head bit appears one edge after the enable is seen.
- R6: A strobe raised while enable is high has no effect on the ring or the output sequence.
- R7: Pattern bits at or above the ring length are ignored.
- R8: Select 3 uses a built-in 25-bit pattern with four runs of ones (output periods 6, 6, 6 and 7 input cycles) and ignores the pattern field. The average ratio is 6.25.
- R9: Over whole ring laps, the number of rising output edges equals the ring length divided by the ratio. Examples:
  - Select 0: 0x0AAA divides by 2, 0x0DB6 by 3, 0x0CCC by 4, 0x0E38 by 6 and 0x0FC0 by 12.
  - Select 1: 0x36CC divides by 3.5, 0x3C78 by 7 and 0x3F80 by 14.
  - Select 2: 0x5294 divides by 2.5, 0x6666 by 3.75, 0x739C by 5, 0x78F0 by 7.5 and 0x7F80 by 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 20 | Control: [19] enable, [18] bypass, [17:16] length select, [15] strobe, [14:0] pattern |
| clk_out | output | 1 | Divided clock (input clock in bypass) |

## Verification
The bench builds the block with its default parameters:

- ring lengths of 12, 14, 15 and 25;
- a 15-bit pattern field;
- a 25-bit ring holding the fixed pattern of four runs.

These values bring every select mode within reach, including the built-in 6.25 mode. For each example pattern, the bench counts rising output edges over eight full laps and compares the count with the ratio. The bench also runs these directed cases:

- gating mid-sequence and resuming;
- a strobe while running;
- pattern bits above the ring length;
- bypass, checked on both clock phases.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_PASS = 2'd3
    } fdiv_state_e;
endpackage

// File: rtl/fdiv_fsm.sv
module fdiv_fsm
    import fdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        byp,
    input  logic        stb,
    output fdiv_state_e state_q,
    output fdiv_state_e state_d
);
    // Target state when the enable is high.
    fdiv_state_e live_st;
    // Target state when the enable is low.
    fdiv_state_e idle_st;

    always_comb begin
        live_st = byp ? ST_PASS : ST_RUN;
        idle_st = stb ? ST_ARM  : ST_OFF;
        unique case (state_q)
            ST_OFF:  state_d = en ? live_st : idle_st;
            ST_ARM:  state_d = en ? live_st : idle_st;
            ST_RUN:  state_d = en ? live_st : idle_st;
            ST_PASS: state_d = en ? live_st : idle_st;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/fdiv_ring.sv
module fdiv_ring #(
    parameter int                 PAT_W  = 15,
    parameter int                 RING_W = 25,
    parameter int                 LEN0   = 12,
    parameter int                 LEN1   = 14,
    parameter int                 LEN2   = 15,
    parameter int                 LEN3   = 25,
    parameter logic [RING_W-1:0]  FIX_PAT = 25'b1110001110001110001111000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [1:0]        sel_in,
    input  logic [PAT_W-1:0]  pat,
    output logic              head,
    output logic [RING_W-1:0] ring_q
);
    localparam int LW = $clog2(RING_W + 1);

    logic [1:0]        sel_q;
    logic [LW-1:0]     len_cur;
    logic [LW-1:0]     len_new;
    logic [RING_W-1:0] rot;
    logic [RING_W-1:0] preset;

    function automatic logic [LW-1:0] len_of(input logic [1:0] s);
        unique case (s)
            2'd0:    len_of = LW'(LEN0);
            2'd1:    len_of = LW'(LEN1);
            2'd2:    len_of = LW'(LEN2);
            default: len_of = LW'(LEN3);
        endcase
    endfunction

    function automatic logic [RING_W-1:0] mask_of(input logic [LW-1:0] n);
        logic [RING_W-1:0] m;
        for (int i = 0; i < RING_W; i++) m[i] = (LW'(i) < n);
        return m;
    endfunction

    always_comb begin
        len_cur = len_of(sel_q);
        len_new = len_of(sel_in);
        head    = ring_q[len_cur - LW'(1)];
        rot     = '0;
        rot[0]  = head;
        for (int i = 1; i < RING_W; i++)
            rot[i] = (LW'(i) < len_cur) ? ring_q[i-1] : 1'b0;
        if (sel_in == 2'd3) preset = FIX_PAT;
        else                preset = RING_W'(pat) & mask_of(len_new);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
            sel_q  <= 2'd0;
        end else if (load) begin
            ring_q <= preset;
            sel_q  <= sel_in;
        end else if (shift) begin
            ring_q <= rot;
        end
    end
endmodule

// File: rtl/fdiv_shift_top.sv
module fdiv_shift_top
    import fdiv_pkg::*;
#(
    parameter int                 PAT_W  = 15,
    parameter int                 RING_W = 25,
    parameter int                 LEN0   = 12,
    parameter int                 LEN1   = 14,
    parameter int                 LEN2   = 15,
    parameter int                 LEN3   = 25,
    parameter logic [RING_W-1:0]  FIX_PAT = 25'b1110001110001110001111000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAT_W+4:0] ctrl_word,
    output logic             clk_out
);
    localparam int CTRL_W  = PAT_W + 5;
    localparam int EN_BIT  = CTRL_W - 1;
    localparam int BYP_BIT = CTRL_W - 2;
    localparam int SEL_HI  = CTRL_W - 3;
    localparam int STB_BIT = PAT_W;

    fdiv_state_e       state_q;
    fdiv_state_e       state_d;
    logic              head;
    logic [RING_W-1:0] ring_q;
    logic              out_q;

    fdiv_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_word[EN_BIT]),
        .byp     (ctrl_word[BYP_BIT]),
        .stb     (ctrl_word[STB_BIT]),
        .state_q (state_q),
        .state_d (state_d)
    );

    fdiv_ring #(
        .PAT_W   (PAT_W),
        .RING_W  (RING_W),
        .LEN0    (LEN0),
        .LEN1    (LEN1),
        .LEN2    (LEN2),
        .LEN3    (LEN3),
        .FIX_PAT (FIX_PAT)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .load   (state_d == ST_ARM),
        .shift  (state_d == ST_RUN),
        .sel_in (ctrl_word[SEL_HI -: 2]),
        .pat    (ctrl_word[PAT_W-1:0]),
        .head   (head),
        .ring_q (ring_q)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= (state_d == ST_RUN) ? head : 1'b0;
    end

    always_comb begin
        unique case (state_q)
            ST_PASS: clk_out = clk;
            default: clk_out = out_q;
        endcase
    end
endmodule

// File: rtl/fdiv_shift_chk.sv
module fdiv_shift_chk
    import fdiv_pkg::*;
#(
    parameter int PAT_W  = 15,
    parameter int RING_W = 25
) (
    input logic              clk,
    input logic              rst,
    input logic [PAT_W+4:0]  ctrl_word,
    input logic              out_q,
    input fdiv_state_e       state_q,
    input logic [RING_W-1:0] ring_q
);
    localparam int EN_BIT  = PAT_W + 4;
    localparam int BYP_BIT = PAT_W + 3;
    localparam int STB_BIT = PAT_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (out_q == 1'b0 && ring_q == '0 && state_q == ST_OFF)); // R1

    AST_BYPASS_STATE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[EN_BIT] && ctrl_word[BYP_BIT]) |=> (state_q == ST_PASS)); // R2

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_word[EN_BIT]) |=> (out_q == 1'b0)); // R3

    AST_RING_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_word[EN_BIT] && !ctrl_word[STB_BIT]) |=> $stable(ring_q)); // R3

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_word[EN_BIT] && ctrl_word[STB_BIT] && ctrl_word[PAT_W+2:PAT_W+1] == 2'd0)
        |=> (ring_q[11:0] == $past(ctrl_word[11:0]) && ring_q[RING_W-1:12] == '0)); // R4 R7

    AST_BYPASS_NO_DIV: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PASS) |-> (out_q == 1'b0)); // R2
endmodule

bind fdiv_shift_top fdiv_shift_chk #(.PAT_W(PAT_W), .RING_W(RING_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .out_q     (out_q),
    .state_q   (state_q),
    .ring_q    (ring_q)
);

// File: tb/fdiv_shift_top_tb_top.sv
`timescale 1ns/1ps
module fdiv_shift_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] ctrl_word = '0;
    logic        clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fdiv_shift_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .clk_out   (clk_out)
    );

    function automatic logic [19:0] cw(input logic en, input logic byp,
                                       input logic [1:0] sel, input logic stb,
                                       input logic [14:0] pat);
        return {en, byp, sel, stb, pat};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Preset protocol: enable low, strobe high, strobe low.
    task automatic preset(input logic [1:0] sel, input logic [14:0] pat);
        @(negedge clk) ctrl_word = cw(1'b0, 1'b0, sel, 1'b0, pat);
        @(negedge clk) ctrl_word = cw(1'b0, 1'b0, sel, 1'b1, pat);
        @(negedge clk) ctrl_word = cw(1'b0, 1'b0, sel, 1'b0, pat);
        @(negedge clk);
    endtask

    // Enables with the given word and counts rising edges over 8 laps.
    task automatic count_rises(input logic [19:0] run_word, input int len, output int rises);
        logic prev;
        logic cur;
        ctrl_word = run_word;
        @(negedge clk) prev = clk_out;
        rises = 0;
        for (int i = 0; i < 8 * len; i++) begin
            @(negedge clk) cur = clk_out;
            if (!prev && cur) rises++;
            prev = cur;
        end
        ctrl_word = cw(1'b0, 1'b0, 2'd0, 1'b0, 15'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        int highs;
        rst = 1'b1;
        ctrl_word = '0;
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(clk_out), 0);
        rst = 1'b0;
        ctrl_word = cw(1'b1, 1'b0, 2'd0, 1'b0, 15'h0);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
        end
        check("R1 cleared ring after reset", highs, 0);
        ctrl_word = '0;
        @(negedge clk);
    endtask

    task automatic t_ratio(input string req, input logic [1:0] sel, input logic [14:0] pat,
                           input int len, input int num, input int den);
        int rises;
        preset(sel, pat);
        count_rises(cw(1'b1, 1'b0, sel, 1'b0, pat), len, rises);
        check(req, rises, (8 * len * den) / num);
    endtask

    task automatic t_gate();
        int got;
        preset(2'd0, 15'h0FC0);
        ctrl_word = cw(1'b1, 1'b0, 2'd0, 1'b0, 15'h0FC0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) check("R5 first head bits", int'(clk_out), 1);
        end
        ctrl_word = cw(1'b0, 1'b0, 2'd0, 1'b0, 15'h0FC0);
        got = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (clk_out) got++;
        end
        check("R3 gated output low", got, 0);
        ctrl_word = cw(1'b1, 1'b0, 2'd0, 1'b0, 15'h0FC0);
        got = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) got = (got << 1) | int'(clk_out);
        end
        check("R3 resume position", got, 4'b1110);
        ctrl_word = '0;
        @(negedge clk);
    endtask

    task automatic t_strobe_running();
        int rises;
        preset(2'd0, 15'h0AAA);
        count_rises(cw(1'b1, 1'b0, 2'd0, 1'b1, 15'h0FC0), 12, rises);
        check("R6 strobe ignored while enabled", rises, 48);
    endtask

    task automatic t_bypass();
        int bad;
        preset(2'd0, 15'h0FC0);
        ctrl_word = cw(1'b1, 1'b1, 2'd0, 1'b0, 15'h0FC0);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk) #5;
            if (clk_out !== 1'b1) bad++;
            @(negedge clk) #5;
            if (clk_out !== 1'b0) bad++;
        end
        check("R2 bypass follows input clock", bad, 0);
        ctrl_word = '0;
        @(negedge clk);
        @(negedge clk);
        check("R3 output low after bypass gated", int'(clk_out), 0);
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_ratio("R9 sel0 div2",     2'd0, 15'h0AAA, 12, 2, 1);
        t_ratio("R9 sel0 div3",     2'd0, 15'h0DB6, 12, 3, 1);
        t_ratio("R9 sel0 div4",     2'd0, 15'h0CCC, 12, 4, 1);
        t_ratio("R9 sel0 div6",     2'd0, 15'h0E38, 12, 6, 1);
        t_ratio("R5 R9 sel0 div12", 2'd0, 15'h0FC0, 12, 12, 1);
        t_ratio("R5 R9 sel1 div3.5", 2'd1, 15'h36CC, 14, 7, 2);
        t_ratio("R9 sel1 div7",     2'd1, 15'h3C78, 14, 7, 1);
        t_ratio("R9 sel1 div14",    2'd1, 15'h3F80, 14, 14, 1);
        t_ratio("R5 R9 sel2 div3.75", 2'd2, 15'h6666, 15, 15, 4);
        t_ratio("R9 sel2 div5",     2'd2, 15'h739C, 15, 5, 1);
        t_ratio("R9 sel2 div7.5",   2'd2, 15'h78F0, 15, 15, 2);
        t_ratio("R9 sel2 div15",    2'd2, 15'h7F80, 15, 15, 1);
        t_ratio("R9 sel2 div2.5",   2'd2, 15'h5294, 15, 5, 2);
        t_ratio("R8 sel3 div6.25",  2'd3, 15'h0000, 25, 25, 4);
        t_ratio("R8 sel3 pattern field ignored", 2'd3, 15'h5555, 25, 25, 4);
        t_ratio("R7 R4 upper pattern bits ignored", 2'd0, 15'h7AAA, 12, 2, 1);
        t_gate();
        t_strobe_running();
        t_bypass();
        finish_run();
    end
endmodule